// File: doc/BRIEF.md
# RS-485 Serial Transmitter with Bus Direction Control

This block is the send half of a UART used on a half-duplex RS-485 bus. Bytes arrive from software or a DMA engine on a valid/ready write port and are held in a four-entry queue. Each byte goes out LSB first on an NRZ line that idles high. Every frame has one low start bit, eight data bits and one high stop bit. The block also drives one direction pin. That pin enables the external transceiver's driver and, through its active-low copy, disables the local receiver.

The direction pin rises one bit period before the first start bit. It stays high across bytes that follow each other, and it falls at the end of the last stop bit. When it falls, a completion flag sets. A level request tells the DMA engine or software to refill the queue once the number of queued bytes drops to a programmed mark or below. The bit period is a 16-bit count of clock cycles.

Write port rules: a byte is taken on any rising clock edge where `wr_valid` and `wr_ready` are both high. `wr_ready` is low only while the queue is full. The writer holds `wr_valid` and `wr_data` steady until the byte is taken. No byte is ever dropped.

Top module: `rs485_tx_dir`

## Requirements
- R1: While reset is held and right after it, `txd` is 1, `dir_out` is 0, `rx_en_n` is 0, `tx_done` is 0 and `wr_ready` is 1.
- R2: Each frame on `txd` is one 0 start bit, then eight data bits least significant first, then one 1 stop bit. Every bit lasts `bit_div` clock cycles, and values 0 and 1 act as 2.
- R3: `dir_out` rises exactly one bit period before the falling edge of the first start bit.
- R4: If another byte is queued when a stop bit ends, its start bit begins on the very next cycle and `dir_out` stays high.
- R5: When a stop bit ends with the queue empty and no write being taken, `dir_out` falls and `tx_done` rises on the same clock edge.
- R6: `rx_en_n` always equals `dir_out`, so the local receiver is disabled whenever the bus is driven.
- R7: Taking a byte on the write port clears `tx_done` on that edge.
- R8: The queue holds 4 bytes. With 4 bytes queued, `wr_ready` is 0 and further writes wait. Every byte taken is sent once, in order.
- R9: `tx_req` is 1 exactly while the number of queued bytes is less than or equal to `tx_mark`.
- R10: If a byte is taken on the same edge that the last stop bit ends, `dir_out` stays high and `tx_done` stays 0. The line then idles high for one bit period before the new start bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous-free synchronous reset |
| wr_valid | input | 1 | Write byte offered |
| wr_ready | output | 1 | Queue can accept a byte |
| wr_data | input | 8 | Byte to send |
| bit_div | input | 16 | Clock cycles per bit |
| tx_mark | input | 3 | Refill request threshold in queued bytes |
| tx_req | output | 1 | Refill request (queued count <= `tx_mark`) |
| tx_done | output | 1 | Last frame fully on the line |
| txd | output | 1 | Serial data, idles high |
| dir_out | output | 1 | Transceiver driver enable |
| rx_en_n | output | 1 | Transceiver receiver enable, active low |

## Verification
The hard case is a write port acceptance that lands on the same edge as the end of the final stop bit. On that edge, the end-of-frame logic would drop the direction pin and set the completion flag, while the write tries to clear the flag and extend the transfer. The bench counts cycles from the moment it writes a single byte and places a second write on exactly that edge. It then checks three things: the direction pin never drops, the flag stays clear, and the new start bit arrives after exactly one idle bit period. Random bursts with random divisors and write gaps can also hit this case by chance, and the line decoder in the bench handles it.

// File: rtl/rs485_tx_pkg.sv
package rs485_tx_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LEAD,
    ST_START,
    ST_DATA,
    ST_STOP
  } tx_state_e;
endpackage

// File: rtl/rs485_tx_fifo.sv
module rs485_tx_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 4,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [W-1:0]  din,
  input  logic          pop,
  output logic [W-1:0]  dout,
  output logic [CW-1:0] count,
  output logic          full,
  output logic          empty
);
  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp, rp;

  always_ff @(posedge clk) begin
    if (push) mem[wp] <= din;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wp    <= '0;
      rp    <= '0;
      count <= '0;
    end else begin
      if (push) wp <= (wp == AW'(DEPTH - 1)) ? '0 : wp + 1'b1;
      if (pop)  rp <= (rp == AW'(DEPTH - 1)) ? '0 : rp + 1'b1;
      count <= count + CW'(push) - CW'(pop);
    end
  end

  assign dout  = mem[rp];
  assign full  = (count == CW'(DEPTH));
  assign empty = (count == '0);
endmodule

// File: rtl/rs485_bit_timer.sv
module rs485_bit_timer #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);
  logic [DIV_W-1:0] eff, cnt;

  // divisors below two are raised to two
  assign eff = (div < DIV_W'(2)) ? DIV_W'(2) : div;

  always_ff @(posedge clk) begin
    if (!rst_n)                cnt <= '0;
    else if (!run || cnt == '0) cnt <= eff - 1'b1;
    else                       cnt <= cnt - 1'b1;
  end

  assign tick = run && (cnt == '0);
endmodule

// File: rtl/rs485_tx_fsm.sv
module rs485_tx_fsm
  import rs485_tx_pkg::*;
#(
  parameter int W     = 8,
  localparam int BW   = (W > 1) ? $clog2(W) : 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  logic         fifo_empty,
  input  logic [W-1:0] fifo_dout,
  input  logic         push_now,
  output logic         pop,
  output logic         run,
  output logic         txd,
  output logic         done
);
  tx_state_e     st;
  logic [W-1:0]  sh;
  logic [BW-1:0] bc;

  assign pop = tick && ((st == ST_LEAD) || (st == ST_STOP && !fifo_empty));
  assign run = (st != ST_IDLE);

  always_comb begin
    case (st)
      ST_START: txd = 1'b0;
      ST_DATA:  txd = sh[0];
      default:  txd = 1'b1;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st   <= ST_IDLE;
      sh   <= '0;
      bc   <= '0;
      done <= 1'b0;
    end else begin
      if (push_now) done <= 1'b0;
      case (st)
        ST_IDLE: if (!fifo_empty) st <= ST_LEAD;
        ST_LEAD: if (tick) begin
          st <= ST_START;
          sh <= fifo_dout;
        end
        ST_START: if (tick) begin
          st <= ST_DATA;
          bc <= '0;
        end
        ST_DATA: if (tick) begin
          sh <= sh >> 1;
          if (bc == BW'(W - 1)) st <= ST_STOP;
          else                  bc <= bc + 1'b1;
        end
        ST_STOP: if (tick) begin
          if (!fifo_empty) begin
            st <= ST_START;
            sh <= fifo_dout;
          end else if (push_now) begin
            st <= ST_LEAD;
          end else begin
            st   <= ST_IDLE;
            done <= 1'b1;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/rs485_tx_dir.sv
module rs485_tx_dir #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 4,
  parameter int DIV_W  = 16,
  localparam int CW    = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_valid,
  output logic              wr_ready,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [DIV_W-1:0]  bit_div,
  input  logic [CW-1:0]     tx_mark,
  output logic              tx_req,
  output logic              tx_done,
  output logic              txd,
  output logic              dir_out,
  output logic              rx_en_n
);
  logic              push, pop, full, empty, tick, run;
  logic [DATA_W-1:0] head;
  logic [CW-1:0]     count;

  assign wr_ready = !full;
  assign push     = wr_valid && !full;
  assign tx_req   = (count <= tx_mark);
  assign dir_out  = run;
  assign rx_en_n  = run;

  rs485_tx_fifo #(.W(DATA_W), .DEPTH(DEPTH)) u_fifo (
    .clk(clk), .rst_n(rst_n), .push(push), .din(wr_data), .pop(pop),
    .dout(head), .count(count), .full(full), .empty(empty)
  );

  rs485_bit_timer #(.DIV_W(DIV_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .run(run), .div(bit_div), .tick(tick)
  );

  rs485_tx_fsm #(.W(DATA_W)) u_fsm (
    .clk(clk), .rst_n(rst_n), .tick(tick), .fifo_empty(empty),
    .fifo_dout(head), .push_now(push), .pop(pop), .run(run),
    .txd(txd), .done(tx_done)
  );
endmodule

// File: rtl/rs485_tx_chk.sv
module rs485_tx_chk (
  input logic clk,
  input logic rst_n,
  input logic wr_valid,
  input logic wr_ready,
  input logic tx_done,
  input logic txd,
  input logic dir_out,
  input logic rx_en_n
);
  // R2
  start_driven_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !txd |-> dir_out);
  // R5
  done_on_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_done) |-> $fell(dir_out));
  // R7
  write_clears_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && wr_ready) |=> !tx_done);
  // R5
  idle_at_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(dir_out) |-> (txd && $past(txd)));
  // R6
  rx_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_en_n == dir_out);
endmodule

bind rs485_tx_dir rs485_tx_chk u_chk (
  .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_ready(wr_ready),
  .tx_done(tx_done), .txd(txd), .dir_out(dir_out), .rx_en_n(rx_en_n)
);

// File: tb/rs485_tx_dir_tb.sv
module rs485_tx_dir_tb;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic        rst_n, wr_valid, wr_ready, tx_req, tx_done, txd, dir_out, rx_en_n;
  logic [7:0]  wr_data;
  logic [15:0] bit_div;
  logic [2:0]  tx_mark;
  logic [7:0]  exp_q[$];
  int n_chk = 0, n_fail = 0;

  rs485_tx_dir u_dut (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_data(wr_data), .bit_div(bit_div), .tx_mark(tx_mark), .tx_req(tx_req),
    .tx_done(tx_done), .txd(txd), .dir_out(dir_out), .rx_en_n(rx_en_n)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
    end
  endtask

  function automatic int eff_div(input int d);
    return (d < 2) ? 2 : d;
  endfunction

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  // writer: called at a negedge, returns at the negedge after the byte is taken
  task automatic push(input logic [7:0] b);
    wr_valid = 1'b1;
    wr_data  = b;
    while (!wr_ready) @(negedge clk);
    exp_q.push_back(b);
    @(negedge clk);
    wr_valid = 1'b0;
  endtask

  task automatic wait_done();
    int guard = 0;
    while (!tx_done && guard < 20000) begin @(negedge clk); guard++; end
    @(negedge clk);
    check(exp_q.size() == 0, "R8", "bytes left unsent", exp_q.size(), 0);
  endtask

  // line decoder
  initial begin
    wait (rst_n === 1'b1);
    forever begin
      int c, d;
      logic [7:0] got, want;
      @(posedge dir_out);
      @(negedge clk);
      d = eff_div(int'(bit_div));
      c = 0;
      while (txd) begin @(negedge clk); c++; end
      check(c == d, "R3", "lead cycles before start", c, d);
      forever begin
        repeat (d / 2) @(negedge clk);
        check(txd == 1'b0, "R2", "start bit level", txd, 0);
        for (int i = 0; i < 8; i++) begin
          repeat (d) @(negedge clk);
          got[i] = txd;
        end
        repeat (d) @(negedge clk);
        check(txd == 1'b1, "R2", "stop bit level", txd, 1);
        check(rx_en_n == 1'b1 && dir_out == 1'b1, "R6", "receiver off while driving",
              rx_en_n, 1);
        want = (exp_q.size() > 0) ? exp_q.pop_front() : 8'hxx;
        check(got === want, "R2", "received byte", got, want);
        repeat (d - d / 2) @(negedge clk);
        if (!txd) begin
          check(dir_out == 1'b1, "R4", "dir held into next frame", dir_out, 1);
        end else if (!dir_out) begin
          check(tx_done == 1'b1, "R5", "done with release", tx_done, 1);
          break;
        end else begin
          check(tx_done == 1'b0, "R10", "done during gap", tx_done, 0);
          repeat (d) @(negedge clk);
          check(txd == 1'b0 && dir_out == 1'b1, "R10", "start after one idle bit", txd, 0);
        end
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; wr_valid = 1'b0; wr_data = '0; bit_div = 16'd8; tx_mark = 3'd0;
    repeat (3) @(negedge clk);
    check(txd == 1 && dir_out == 0 && rx_en_n == 0 && tx_done == 0 && wr_ready == 1,
          "R1", "outputs in reset", {txd, dir_out, rx_en_n, tx_done, wr_ready}, 5'b10001);
    rst_n = 1'b1;
    @(negedge clk);
    check(txd == 1 && dir_out == 0 && rx_en_n == 0 && tx_done == 0 && wr_ready == 1,
          "R1", "outputs after reset", {txd, dir_out, rx_en_n, tx_done, wr_ready}, 5'b10001);
    check(tx_req == 1, "R9", "request with empty queue", tx_req, 1);

    // fill during lead time
    bit_div = 16'd20; tx_mark = 3'd1;
    push(8'hA5); push(8'h3C); push(8'h01);
    check(tx_req == 0, "R9", "3 queued, mark 1", tx_req, 0);
    tx_mark = 3'd3;
    #0;
    check(tx_req == 1, "R9", "3 queued, mark 3", tx_req, 1);
    push(8'hFE);
    check(wr_ready == 0, "R8", "ready with 4 queued", wr_ready, 0);
    check(tx_req == 0, "R9", "4 queued, mark 3", tx_req, 0);
    push(8'h80);
    wait_done();

    // write clears done
    bit_div = 16'd5;
    check(tx_done == 1, "R5", "done before write", tx_done, 1);
    push(8'h5A);
    check(tx_done == 0, "R7", "done after write", tx_done, 0);
    wait_done();

    // write on the edge the last stop bit ends
    bit_div = 16'd6;
    push(8'hC3);
    repeat (11 * 6) @(negedge clk);
    check(wr_ready == 1, "R10", "ready at collision", wr_ready, 1);
    wr_valid = 1'b1; wr_data = 8'h96; exp_q.push_back(8'h96);
    @(negedge clk);
    wr_valid = 1'b0;
    check(dir_out == 1 && tx_done == 0, "R10", "dir and done after collision",
          {dir_out, tx_done}, 2'b10);
    wait_done();

    // clamped divisor
    bit_div = 16'd1;
    push(8'h00); push(8'hFF);
    wait_done();

    // random bursts
    void'($urandom(32'd4851));
    for (int r = 0; r < 12; r++) begin
      int n;
      bit_div = 16'(3 + $urandom % 10);
      n = 1 + $urandom % 6;
      for (int k = 0; k < n; k++) begin
        push(8'($urandom));
        repeat ($urandom % 3) @(negedge clk);
      end
      wait_done();
    end
    finish_run();
  end
endmodule